// File: doc/BRIEF.md
# Calendar Clock Update Engine

This block keeps the wall-clock time and calendar of a real-time clock: seconds, minutes, hours, weekday, date, month and two-digit year, plus seconds, minutes and hours alarm bytes. Software reaches every byte through a small register port with a four-bit address. A one-cycle pulse on `tick`, arriving once per second from an external divider, asks for one advance of the whole time and calendar.

Each byte is kept in packed BCD or in plain binary, and hours are kept in 24-hour or in 12-hour form with a PM flag. The update path decodes the bytes to binary, adds one second with all carries, and encodes the result back into the selected form. Optional daylight-saving handling moves the clock forward one hour in spring and back one hour in autumn.

Software can hold the clock still while it loads a new time. The block raises an update-done flag and an alarm flag, and gates each onto a single interrupt line through its own enable.

Top module: `rtc_tick_engine`

## Requirements
- R1: A `tick` pulse sampled high at one rising edge advances the time by exactly one second at the following rising edge. Without a tick, the time bytes keep their values.
- R2: Control register (address 10) bit 0 is the hold bit. While it is 1, ticks are ignored and software writes to the time bytes take effect. A control write that sets it in the cycle between a tick and its update cancels that update. Ticks seen during the hold are not replayed after it clears.
- R3: With control bit 1 = 0 (BCD), the time bytes count in packed BCD: seconds 0x59 roll to 0x00 and carry into minutes, and minutes 0x09 step to 0x10.
- R4: With control bit 1 = 1 (binary), the time bytes count in binary: seconds 59 roll to 0 and carry, and minutes 9 step to 0x0A.
- R5: With control bit 2 = 0 (12-hour), the hour byte holds 1..12 with bit 7 = PM. 11:59:59 steps to 12:00:00 with the PM bit flipped, and 12:59:59 steps to 1:00:00 with the PM bit kept.
- R6: With control bit 2 = 1 (24-hour), 23:59:59 steps to 00:00:00 and advances the day. The weekday (address 6) counts 1..7 with Sunday = 1 and wraps from 7 to 1.
- R7: The date wraps to 1 after the last day of its month and the month advances. February has 29 days when the year is divisible by four, and 28 days otherwise. Month 12 wraps to 1 and the year advances, with 99 wrapping to 0.
- R8: With control bit 3 = 1 (daylight saving), on a Sunday in April with date 1..7, 01:59:59 steps to 03:00:00.
- R9: With daylight saving on, on a Sunday in October with date 25..31, the first arrival at 01:59:59 steps back to 01:00:00. The next arrival at 01:59:59 steps on to 02:00:00.
- R10: A daylight-saving adjustment is applied only after at least two ordinary updates since the last software write to a time or calendar byte.
- R11: Every update sets flag bit 0 (address 11). `irq` is high while that flag is set and control bit 4 is 1. Flag bit 7 reads the level of `irq`. Writing 1 to flag bit 0 or bit 1 clears that flag.
- R12: An update whose new seconds, minutes and hours each match their alarm byte sets flag bit 1. An alarm byte with its top two bits set (0xC0..0xFF) matches any value. With control bit 5 = 1, the alarm flag drives `irq`.
- R13: Reset clears control bits 4 and 5 and both flags, and leaves control bits 0..3 as written.
- R14: When an update and a software write that clears a flag land on the same edge, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for the enables, flags and sequencing state |
| tick | input | 1 | One-cycle pulse requesting a one-second advance |
| reg_addr | input | 4 | Register address (0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 weekday, 7 date, 8 month, 9 year, 10 control, 11 flags) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land on the same edge. In the first, the update that follows a tick coincides with software clearing the flags. In the second, it coincides with software setting the hold bit. The bench lines up both cases by driving the flag write, or the control write, in the cycle right after the tick pulse, so that the write and the update share one rising edge. It then reads the flags back (both still set) or the seconds byte (unchanged) to decide which side won.

// File: rtl/rtc_tick_engine.sv
module rtc_tick_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);

  localparam logic [3:0] A_SEC = 4'd0, A_ASEC = 4'd1, A_MIN = 4'd2, A_AMIN = 4'd3,
                         A_HR = 4'd4, A_AHR = 4'd5, A_WDAY = 4'd6, A_DATE = 4'd7,
                         A_MON = 4'd8, A_YR = 4'd9, A_CTL = 4'd10, A_FLG = 4'd11;

  logic [7:0] sec_q, asec_q, min_q, amin_q, hr_q, ahr_q, wday_q, date_q, mon_q, yr_q;
  logic       inh_q, bin_q, h24_q, dst_q, uie_q, aie_q;
  logic       uf_q, af_q, pend_q, fall_done_q;
  logic [1:0] norm_q;

  function automatic logic [6:0] dec(input logic [7:0] b, input logic binm);
    return binm ? b[6:0] : ({3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]});
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic binm);
    logic [3:0] t;
    logic [3:0] u;
    t = 4'(v / 7'd10);
    u = 4'(v % 7'd10);
    return binm ? {1'b0, v} : {t, u};
  endfunction

  function automatic logic [6:0] mlen(input logic [6:0] mo, input logic [1:0] ylo);
    case (mo)
      7'd2:                      return (ylo == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

  function automatic logic hit(input logic [7:0] alarm, input logic [7:0] val);
    return (alarm[7:6] == 2'b11) || (alarm == val);
  endfunction

  // decode current bytes to binary
  logic [6:0] s, m, h, hraw, w, d, mo, y;
  assign s    = dec(sec_q, bin_q);
  assign m    = dec(min_q, bin_q);
  assign hraw = dec({1'b0, hr_q[6:0]}, bin_q);
  assign h    = h24_q ? dec(hr_q, bin_q)
                      : ((hraw == 7'd12 ? 7'd0 : hraw) + (hr_q[7] ? 7'd12 : 7'd0));
  assign w    = dec(wday_q, bin_q);
  assign d    = dec(date_q, bin_q);
  assign mo   = dec(mon_q, bin_q);
  assign y    = dec(yr_q, bin_q);

  // next-second arithmetic
  logic [6:0] ns, nm, nh, nw, nd, nmo, ny, h12, hmod;
  logic       day_carry, at_trig, spring, fall;

  assign at_trig = dst_q && (norm_q == 2'd2) && s == 7'd59 && m == 7'd59 && h == 7'd1 && w == 7'd1;
  assign spring  = at_trig && mo == 7'd4 && d <= 7'd7;
  assign fall    = at_trig && mo == 7'd10 && d >= 7'd25 && !fall_done_q;

  always_comb begin
    ns = s; nm = m; nh = h; nw = w; nd = d; nmo = mo; ny = y;
    day_carry = 1'b0;
    if (spring) begin
      ns = 7'd0; nm = 7'd0; nh = 7'd3;
    end else if (fall) begin
      ns = 7'd0; nm = 7'd0; nh = 7'd1;
    end else if (s >= 7'd59) begin
      ns = 7'd0;
      if (m >= 7'd59) begin
        nm = 7'd0;
        if (h >= 7'd23) begin
          nh = 7'd0;
          day_carry = 1'b1;
        end else nh = h + 7'd1;
      end else nm = m + 7'd1;
    end else ns = s + 7'd1;
    if (day_carry) begin
      nw = (w >= 7'd7) ? 7'd1 : w + 7'd1;
      if (d >= mlen(mo, y[1:0])) begin
        nd = 7'd1;
        if (mo >= 7'd12) begin
          nmo = 7'd1;
          ny  = (y >= 7'd99) ? 7'd0 : y + 7'd1;
        end else nmo = mo + 7'd1;
      end else nd = d + 7'd1;
    end
  end

  assign hmod = (nh >= 7'd12) ? nh - 7'd12 : nh;
  assign h12  = (hmod == 7'd0) ? 7'd12 : hmod;

  logic [7:0] sec_n, min_n, hr_n, h12_enc;
  assign sec_n   = enc(ns, bin_q);
  assign min_n   = enc(nm, bin_q);
  assign h12_enc = enc(h12, bin_q);
  assign hr_n    = h24_q ? enc(nh, bin_q) : {nh >= 7'd12, h12_enc[6:0]};

  // control decode
  logic wr_ctl, wr_flg, abort, do_upd, alarm_hit, tm_wr;
  assign wr_ctl    = reg_wr && reg_addr == A_CTL;
  assign wr_flg    = reg_wr && reg_addr == A_FLG;
  assign abort     = wr_ctl && reg_wdata[0];
  assign do_upd    = pend_q && !inh_q && !abort;
  assign alarm_hit = hit(asec_q, sec_n) && hit(amin_q, min_n) && hit(ahr_q, hr_n);
  assign tm_wr     = reg_wr && (reg_addr == A_SEC || reg_addr == A_MIN || reg_addr == A_HR ||
                                reg_addr == A_WDAY || reg_addr == A_DATE || reg_addr == A_MON ||
                                reg_addr == A_YR);

  // time and calendar bytes: software write wins over the update
  always_ff @(posedge clk) begin
    if (reg_wr && reg_addr == A_SEC) sec_q <= reg_wdata;
    else if (do_upd) sec_q <= sec_n;
    if (reg_wr && reg_addr == A_MIN) min_q <= reg_wdata;
    else if (do_upd) min_q <= min_n;
    if (reg_wr && reg_addr == A_HR) hr_q <= reg_wdata;
    else if (do_upd) hr_q <= hr_n;
    if (reg_wr && reg_addr == A_WDAY) wday_q <= reg_wdata;
    else if (do_upd) wday_q <= enc(nw, bin_q);
    if (reg_wr && reg_addr == A_DATE) date_q <= reg_wdata;
    else if (do_upd) date_q <= enc(nd, bin_q);
    if (reg_wr && reg_addr == A_MON) mon_q <= reg_wdata;
    else if (do_upd) mon_q <= enc(nmo, bin_q);
    if (reg_wr && reg_addr == A_YR) yr_q <= reg_wdata;
    else if (do_upd) yr_q <= enc(ny, bin_q);
    if (reg_wr && reg_addr == A_ASEC) asec_q <= reg_wdata;
    if (reg_wr && reg_addr == A_AMIN) amin_q <= reg_wdata;
    if (reg_wr && reg_addr == A_AHR)  ahr_q  <= reg_wdata;
  end

  // mode bits survive reset
  always_ff @(posedge clk) begin
    if (wr_ctl) begin
      inh_q <= reg_wdata[0];
      bin_q <= reg_wdata[1];
      h24_q <= reg_wdata[2];
      dst_q <= reg_wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uie_q       <= 1'b0;
      aie_q       <= 1'b0;
      uf_q        <= 1'b0;
      af_q        <= 1'b0;
      pend_q      <= 1'b0;
      fall_done_q <= 1'b0;
      norm_q      <= 2'd0;
    end else begin
      pend_q <= tick && !inh_q;
      if (wr_ctl) begin
        uie_q <= reg_wdata[4];
        aie_q <= reg_wdata[5];
      end
      if (do_upd) uf_q <= 1'b1;
      else if (wr_flg && reg_wdata[0]) uf_q <= 1'b0;
      if (do_upd && alarm_hit) af_q <= 1'b1;
      else if (wr_flg && reg_wdata[1]) af_q <= 1'b0;
      if (do_upd && fall) fall_done_q <= 1'b1;
      else if (do_upd && day_carry) fall_done_q <= 1'b0;
      if (tm_wr) norm_q <= 2'd0;
      else if (do_upd && norm_q != 2'd2) norm_q <= norm_q + 2'd1;
    end
  end

  assign irq = (uf_q && uie_q) || (af_q && aie_q);

  always_comb begin
    case (reg_addr)
      A_SEC:   reg_rdata = sec_q;
      A_ASEC:  reg_rdata = asec_q;
      A_MIN:   reg_rdata = min_q;
      A_AMIN:  reg_rdata = amin_q;
      A_HR:    reg_rdata = hr_q;
      A_AHR:   reg_rdata = ahr_q;
      A_WDAY:  reg_rdata = wday_q;
      A_DATE:  reg_rdata = date_q;
      A_MON:   reg_rdata = mon_q;
      A_YR:    reg_rdata = yr_q;
      A_CTL:   reg_rdata = {2'b00, aie_q, uie_q, dst_q, h24_q, bin_q, inh_q};
      A_FLG:   reg_rdata = {irq, 5'b0, af_q, uf_q};
      default: reg_rdata = 8'h00;
    endcase
  end

  a_r2_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q && !reg_wr) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)));

  a_r11_flag_after_update: assert property (@(posedge clk) disable iff (!rst_n)
    do_upd |=> uf_q);

  a_r12_alarm_from_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af_q) |-> $past(do_upd));

  a_r13_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!uie_q && !aie_q && !uf_q && !af_q));

  a_r14_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (do_upd && alarm_hit && wr_flg && reg_wdata[1]) |=> af_q);

endmodule

// File: tb/rtc_tick_engine_tb.sv
module rtc_tick_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;
  int checks = 0;
  int fails = 0;

  localparam logic [3:0] SEC = 0, ASEC = 1, MIN = 2, AMIN = 3, HR = 4, AHR = 5,
                         WD = 6, DT = 7, MO = 8, YR = 9, CTL = 10, FLG = 11;

  always #5 clk = ~clk;

  rtc_tick_engine u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s: addr %0d got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1;
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] ctl, input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [7:0] w, input logic [7:0] d,
                          input logic [7:0] mo, input logic [7:0] y);
    wr(CTL, ctl | 8'h01);
    wr(SEC, s); wr(MIN, m); wr(HR, h); wr(WD, w); wr(DT, d); wr(MO, mo); wr(YR, y);
    wr(CTL, ctl);
  endtask

  task automatic t_reset();
    wr(CTL, 8'h3E);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(CTL, 8'h0E, "R13 enables cleared, modes kept");
    chk(FLG, 8'h00, "R13 flags cleared");
  endtask

  task automatic t_bcd();
    set_time(8'h04, 8'h59, 8'h09, 8'h13, 8'h03, 8'h15, 8'h06, 8'h24);
    one_tick();
    chk(SEC, 8'h00, "R3 seconds wrap");
    chk(MIN, 8'h10, "R3 BCD minute carry");
    chk(HR, 8'h13, "R1 hour unchanged");
    repeat (5) @(negedge clk);
    chk(SEC, 8'h00, "R1 no tick no advance");
    one_tick();
    chk(SEC, 8'h01, "R1 one second per tick");
  endtask

  task automatic t_bin();
    set_time(8'h06, 8'd59, 8'd9, 8'd5, 8'd3, 8'd10, 8'd6, 8'd24);
    one_tick();
    chk(SEC, 8'h00, "R4 binary seconds wrap");
    chk(MIN, 8'h0A, "R4 binary minute step");
    set_time(8'h06, 8'd59, 8'd59, 8'd23, 8'd3, 8'd31, 8'd1, 8'd24);
    one_tick();
    chk(DT, 8'h01, "R4 binary date wrap");
    chk(MO, 8'h02, "R4 binary month step");
  endtask

  task automatic t_12h();
    set_time(8'h00, 8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h06, 8'h24);
    one_tick();
    chk(HR, 8'h92, "R5 11 AM to 12 PM");
    set_time(8'h00, 8'h59, 8'h59, 8'h92, 8'h02, 8'h10, 8'h06, 8'h24);
    one_tick();
    chk(HR, 8'h81, "R5 12 PM to 1 PM");
    set_time(8'h00, 8'h59, 8'h59, 8'h91, 8'h07, 8'h10, 8'h06, 8'h24);
    one_tick();
    chk(HR, 8'h12, "R5 11 PM to 12 AM");
    chk(WD, 8'h01, "R6 weekday 7 to 1");
  endtask

  task automatic t_calendar();
    set_time(8'h04, 8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24);
    one_tick();
    chk(HR, 8'h00, "R6 midnight");
    chk(WD, 8'h01, "R6 weekday wrap");
    chk(DT, 8'h29, "R7 leap February 29");
    one_tick();
    set_time(8'h04, 8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    one_tick();
    chk(DT, 8'h01, "R7 leap Feb end");
    chk(MO, 8'h03, "R7 leap month step");
    set_time(8'h04, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    one_tick();
    chk(MO, 8'h03, "R7 common Feb end");
    set_time(8'h04, 8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23);
    one_tick();
    chk(MO, 8'h05, "R7 30-day month");
    set_time(8'h04, 8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
    one_tick();
    chk(DT, 8'h01, "R7 new year date");
    chk(MO, 8'h01, "R7 new year month");
    chk(YR, 8'h00, "R7 year 99 wrap");
  endtask

  task automatic t_hold();
    set_time(8'h04, 8'h10, 8'h00, 8'h08, 8'h02, 8'h10, 8'h06, 8'h24);
    wr(CTL, 8'h05);
    one_tick();
    chk(SEC, 8'h10, "R2 tick ignored on hold");
    wr(CTL, 8'h04);
    repeat (3) @(negedge clk);
    chk(SEC, 8'h10, "R2 no replay after hold");
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; reg_addr = CTL; reg_wdata = 8'h05; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    chk(SEC, 8'h10, "R2 pending update aborted");
    wr(CTL, 8'h04);
    one_tick();
    chk(SEC, 8'h11, "R2 runs after release");
  endtask

  task automatic t_dst();
    set_time(8'h0C, 8'h57, 8'h59, 8'h01, 8'h01, 8'h05, 8'h04, 8'h24);
    repeat (3) one_tick();
    chk(HR, 8'h03, "R8 spring hour");
    chk(MIN, 8'h00, "R8 spring minute");
    set_time(8'h0C, 8'h59, 8'h59, 8'h01, 8'h01, 8'h05, 8'h04, 8'h24);
    one_tick();
    chk(HR, 8'h02, "R10 no jump right after write");
    set_time(8'h0C, 8'h57, 8'h59, 8'h01, 8'h01, 8'h27, 8'h10, 8'h24);
    repeat (3) one_tick();
    chk(HR, 8'h01, "R9 fall back hour");
    chk(MIN, 8'h00, "R9 fall back minute");
    set_time(8'h0C, 8'h57, 8'h59, 8'h01, 8'h01, 8'h27, 8'h10, 8'h24);
    repeat (3) one_tick();
    chk(HR, 8'h02, "R9 second pass normal");
  endtask

  task automatic t_flags();
    set_time(8'h14, 8'h00, 8'h00, 8'h08, 8'h02, 8'h10, 8'h06, 8'h24);
    wr(FLG, 8'h03);
    one_tick();
    chk(FLG, 8'h81, "R11 update flag and irq");
    chk_irq(1'b1, "R11 irq high");
    wr(FLG, 8'h01);
    chk(FLG, 8'h00, "R11 flag cleared");
    chk_irq(1'b0, "R11 irq low");
    wr(CTL, 8'h04);
    one_tick();
    chk(FLG, 8'h01, "R11 flag without irq");
    wr(FLG, 8'h03);
  endtask

  task automatic t_alarm();
    set_time(8'h24, 8'h29, 8'h00, 8'h08, 8'h02, 8'h10, 8'h06, 8'h24);
    wr(ASEC, 8'h30); wr(AMIN, 8'hC0); wr(AHR, 8'hFF);
    wr(FLG, 8'h03);
    one_tick();
    chk(FLG, 8'h83, "R12 alarm match with wildcards");
    wr(FLG, 8'h03);
    one_tick();
    chk(FLG, 8'h01, "R12 no match no alarm");
    chk_irq(1'b0, "R12 irq follows alarm only");
    wr(ASEC, 8'hC0);
    wr(FLG, 8'h03);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; reg_addr = FLG; reg_wdata = 8'h03; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    chk(FLG, 8'h83, "R14 set beats clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bcd();
    t_bin();
    t_12h();
    t_calendar();
    t_hold();
    t_dst();
    t_flags();
    t_alarm();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule